// File: doc/BRIEF.md
# PCI Configuration Access Translator

This block sits between a system bus and a PCI bus model. It turns one word access that lands in a 64 KB configuration window into a single configuration-cycle request. The request carries the target bus number, the device/function number and the dword register offset. The bus number is not taken from the access address. Software programs it in a field of a control register before it starts the access. When the target is bus 0, every slot except slot 0 is moved six slots up before the cycle goes out.

The system bus is big-endian and the PCI side is little-endian, so the block reverses the byte order of the data in both directions. Completion and error are recorded in two sticky status bits, and software clears each one by writing 1 to it. Only one configuration cycle can be outstanding at a time. While a cycle is open the request port holds ready low. A read that completes with an error returns all ones. An access whose address is not word aligned never reaches the PCI side: it completes at once and reports an error.

A typical driver sequence is: clear both status bits, program the bus field, issue the access, then poll the done bit. It reads the error bit before it uses the returned data.

Top module: `pcfg_xlate`

## Requirements
- R1: The control word holds the target bus number in bits 23:16. It reads back at that position with every other bit zero, resets to 0, and each issued cycle carries the value it held when the request was accepted.
- R2: Window address bits 15:8 form the device/function number (slot in 15:11, function in 10:8), and bits 7:2 form the dword register offset sent with the cycle.
- R3: If the bus number is 0 and the slot is non-zero, the device/function number sent is the decoded value plus 48 (slot plus 6, function kept). For slot 0, or for any non-zero bus, it is sent unchanged.
- R4: Status bit 20 (done) sets on the clock edge at which a configuration cycle completes, for reads and for writes.
- R5: Status bit 19 (error) sets when a cycle completes with its error input high. A completion without error leaves bit 19 as it was, and a new request does not clear either status bit.
- R6: A status write of 1 to bit 19 or bit 20 clears that bit, and a write of 0 leaves it unchanged. When a set and a clear land in the same cycle, the set wins.
- R7: Write data is byte-reversed on its way to the cycle port (request byte 0, bits 7:0, appears in cycle bits 31:24). Read data is byte-reversed the same way on its way back.
- R8: A read that completes with error returns 0xFFFFFFFF as response data. Write responses carry zero data.
- R9: While a cycle is outstanding, req_ready is low, and cyc_req stays high with bus, device/function, offset and write data held until cyc_done.
- R10: An accepted request with address bits 1:0 non-zero issues no cycle. On the next cycle it gives a response and sets both bit 19 and bit 20. A read of this kind returns 0xFFFFFFFF.
- R11: After reset, req_ready is high, cyc_req and rsp_valid are low, and both status bits read 0.
- R12: rsp_valid is a one-cycle pulse in the cycle after completion (cyc_done seen, or misaligned request accepted).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Window access request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 16 | Byte address inside the configuration window |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data, system byte order |
| rsp_valid | output | 1 | Access completed (one-cycle pulse) |
| rsp_rdata | output | 32 | Read data, system byte order |
| reg_sel | input | 1 | Register select: 0 control, 1 status |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register contents |
| cyc_req | output | 1 | Configuration cycle outstanding |
| cyc_write | output | 1 | Cycle direction, 1 = write |
| cyc_bus | output | 8 | Target bus number |
| cyc_devfn | output | 8 | Target device/function after remap |
| cyc_regofs | output | 6 | Dword register offset |
| cyc_wdata | output | 32 | Write data, PCI byte order |
| cyc_done | input | 1 | Cycle finished |
| cyc_err | input | 1 | Cycle finished with error |
| cyc_rdata | input | 32 | Read data, PCI byte order |

## Verification
The bench checks the slot remap at its edges. On bus 0 it checks a non-zero slot, slot 0 itself, and a non-zero bus where the remap must not apply. A design that decided the remap from the address instead of the control field, or that remapped slot 0, would put the wrong device/function on the cycle port. It feeds asymmetric byte patterns in both directions, so a missing or half swap shows up as a data mismatch. It also gives an errored read, where a design that passed the PCI data through would not return all ones. The status bits are driven through stickiness, write-0-no-effect and per-bit clear. A design that cleared them on a new request, or cleared both on a single-bit write, fails there. Misaligned addresses are shown to raise no cycle at all.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

    localparam int BUS_W        = 8;
    localparam int BUS_LSB      = 16;
    localparam int STS_DONE_BIT = 20;
    localparam int STS_ERR_BIT  = 19;
    localparam int FUNC_W       = 3;
    localparam int SLOT_W       = 5;
    localparam int DEVFN_W      = SLOT_W + FUNC_W;
    localparam int REG_W        = 6;
    localparam int REG_LSB      = 2;
    localparam int DEVFN_LSB    = REG_LSB + REG_W;
    localparam int BUS0_SHIFT   = 6;

    typedef struct packed {
        logic [BUS_W-1:0]   bus;
        logic [DEVFN_W-1:0] devfn;
        logic [REG_W-1:0]   regofs;
    } cfg_tgt_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } seq_state_e;

    // Bus 0 slots other than 0 move up by BUS0_SHIFT slots.
    function automatic logic [DEVFN_W-1:0] remap_devfn(
        input logic [BUS_W-1:0]   bus,
        input logic [DEVFN_W-1:0] devfn
    );
        logic [DEVFN_W-1:0] delta;
        delta = DEVFN_W'(BUS0_SHIFT << FUNC_W);
        if (bus == '0 && devfn[DEVFN_W-1:FUNC_W] != '0)
            return devfn + delta;
        return devfn;
    endfunction

endpackage

// File: rtl/pcfg_bswap.sv
module pcfg_bswap #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    localparam int NBYTES = DATA_W / 8;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign dout[8*b +: 8] = din[8*(NBYTES-1-b) +: 8];
    end
endmodule

// File: rtl/pcfg_addr_dec.sv
module pcfg_addr_dec
    import pcfg_pkg::*;
#(
    parameter int WIN_AW = 16
) (
    input  logic [WIN_AW-1:0] addr,
    input  logic [BUS_W-1:0]  bus,
    output cfg_tgt_t          tgt,
    output logic              misaligned
);
    logic [DEVFN_W-1:0] raw_devfn;

    assign raw_devfn  = addr[DEVFN_LSB +: DEVFN_W];
    assign misaligned = |addr[REG_LSB-1:0];

    always_comb begin
        tgt.bus    = bus;
        tgt.devfn  = remap_devfn(bus, raw_devfn);
        tgt.regofs = addr[REG_LSB +: REG_W];
    end
endmodule

// File: rtl/pcfg_status.sv
module pcfg_status
    import pcfg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_done,
    input  logic set_err,
    input  logic clr_done,
    input  logic clr_err,
    output logic done,
    output logic err
);
    localparam int NBITS = 2;

    logic [NBITS-1:0] set_v, clr_v, bits_q;

    assign set_v = {set_err, set_done};
    assign clr_v = {clr_err, clr_done};

    for (genvar i = 0; i < NBITS; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                bits_q[i] <= 1'b0;
            else if (set_v[i])
                bits_q[i] <= 1'b1;
            else if (clr_v[i])
                bits_q[i] <= 1'b0;
        end
    end

    assign done = bits_q[0];
    assign err  = bits_q[1];
endmodule

// File: rtl/pcfg_xlate.sv
module pcfg_xlate
    import pcfg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int WIN_AW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [WIN_AW-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              reg_sel,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              cyc_req,
    output logic              cyc_write,
    output logic [7:0]        cyc_bus,
    output logic [7:0]        cyc_devfn,
    output logic [5:0]        cyc_regofs,
    output logic [DATA_W-1:0] cyc_wdata,
    input  logic              cyc_done,
    input  logic              cyc_err,
    input  logic [DATA_W-1:0] cyc_rdata
);
    logic [BUS_W-1:0]  bus_q;
    seq_state_e        state_q;
    cfg_tgt_t          dec_tgt, tgt_q;
    logic              dec_mis;
    logic              write_q;
    logic [DATA_W-1:0] wdata_sw, rdata_sw, wdata_q;
    logic              accept, finish;
    logic              sts_done_w, sts_err_w;

    // Control word: bus number field only.
    always_ff @(posedge clk) begin
        if (rst)
            bus_q <= '0;
        else if (reg_we && !reg_sel)
            bus_q <= reg_wdata[BUS_LSB +: BUS_W];
    end

    pcfg_addr_dec #(.WIN_AW(WIN_AW)) u_dec (
        .addr       (req_addr),
        .bus        (bus_q),
        .tgt        (dec_tgt),
        .misaligned (dec_mis)
    );

    pcfg_bswap #(.DATA_W(DATA_W)) u_swap_w (.din(req_wdata), .dout(wdata_sw));
    pcfg_bswap #(.DATA_W(DATA_W)) u_swap_r (.din(cyc_rdata), .dout(rdata_sw));

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign finish    = (state_q == ST_WAIT) && cyc_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            tgt_q     <= '0;
            write_q   <= 1'b0;
            wdata_q   <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (dec_mis) begin
                            rsp_valid <= 1'b1;
                            rsp_rdata <= req_write ? '0 : '1;
                        end else begin
                            state_q <= ST_WAIT;
                            tgt_q   <= dec_tgt;
                            write_q <= req_write;
                            wdata_q <= wdata_sw;
                        end
                    end
                end
                ST_WAIT: begin
                    if (cyc_done) begin
                        state_q   <= ST_IDLE;
                        rsp_valid <= 1'b1;
                        if (write_q)
                            rsp_rdata <= '0;
                        else if (cyc_err)
                            rsp_rdata <= '1;
                        else
                            rsp_rdata <= rdata_sw;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    pcfg_status u_sts (
        .clk      (clk),
        .rst      (rst),
        .set_done (finish || (accept && dec_mis)),
        .set_err  ((finish && cyc_err) || (accept && dec_mis)),
        .clr_done (reg_we && reg_sel && reg_wdata[STS_DONE_BIT]),
        .clr_err  (reg_we && reg_sel && reg_wdata[STS_ERR_BIT]),
        .done     (sts_done_w),
        .err      (sts_err_w)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_sel) begin
            reg_rdata[STS_DONE_BIT] = sts_done_w;
            reg_rdata[STS_ERR_BIT]  = sts_err_w;
        end else begin
            reg_rdata[BUS_LSB +: BUS_W] = bus_q;
        end
    end

    assign cyc_req    = (state_q == ST_WAIT);
    assign cyc_write  = write_q;
    assign cyc_bus    = tgt_q.bus;
    assign cyc_devfn  = tgt_q.devfn;
    assign cyc_regofs = tgt_q.regofs;
    assign cyc_wdata  = wdata_q;
endmodule

// File: rtl/pcfg_xlate_chk.sv
module pcfg_xlate_chk
    import pcfg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int WIN_AW = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [WIN_AW-1:0] req_addr,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              reg_sel,
    input logic              reg_we,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              cyc_req,
    input logic              cyc_write,
    input logic [7:0]        cyc_bus,
    input logic [7:0]        cyc_devfn,
    input logic [5:0]        cyc_regofs,
    input logic              cyc_done,
    input logic              cyc_err,
    input logic              sts_done,
    input logic              sts_err
);
    logic mis_acc, done_evt;
    assign mis_acc  = req_valid && req_ready && (req_addr[1:0] != 2'b00);
    assign done_evt = cyc_req && cyc_done;

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        cyc_req |-> !req_ready); // R9
    AST_CYC_HELD: assert property (@(posedge clk) disable iff (rst)
        cyc_req && !cyc_done |=> cyc_req && $stable(cyc_devfn) && $stable(cyc_bus)
                                 && $stable(cyc_regofs)); // R9
    AST_DONE_SETS: assert property (@(posedge clk) disable iff (rst)
        done_evt |=> sts_done && rsp_valid); // R4
    AST_ERR_SETS: assert property (@(posedge clk) disable iff (rst)
        done_evt && cyc_err |=> sts_err); // R5
    AST_ERR_READ_ONES: assert property (@(posedge clk) disable iff (rst)
        done_evt && cyc_err && !cyc_write |=> rsp_rdata == '1); // R8
    AST_MISALIGN_NO_CYC: assert property (@(posedge clk) disable iff (rst)
        mis_acc |=> !cyc_req && sts_err && sts_done && rsp_valid); // R10
    AST_RSP_CAUSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(done_evt || mis_acc)); // R12
    AST_DONE_W1C: assert property (@(posedge clk) disable iff (rst)
        reg_we && reg_sel && reg_wdata[STS_DONE_BIT] && !done_evt && !mis_acc
        |=> !sts_done); // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        sts_err && !(reg_we && reg_sel && reg_wdata[STS_ERR_BIT]) |=> sts_err); // R5
endmodule

bind pcfg_xlate pcfg_xlate_chk #(.DATA_W(DATA_W), .WIN_AW(WIN_AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .reg_sel    (reg_sel),
    .reg_we     (reg_we),
    .reg_wdata  (reg_wdata),
    .cyc_req    (cyc_req),
    .cyc_write  (cyc_write),
    .cyc_bus    (cyc_bus),
    .cyc_devfn  (cyc_devfn),
    .cyc_regofs (cyc_regofs),
    .cyc_done   (cyc_done),
    .cyc_err    (cyc_err),
    .sts_done   (sts_done_w),
    .sts_err    (sts_err_w)
);

// File: tb/pcfg_xlate_tb.sv
module pcfg_xlate_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [31:0] rsp_rdata;
    logic        reg_sel = 1'b0, reg_we = 1'b0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        cyc_req, cyc_write;
    logic [7:0]  cyc_bus, cyc_devfn;
    logic [5:0]  cyc_regofs;
    logic [31:0] cyc_wdata;
    logic        cyc_done = 1'b0, cyc_err = 1'b0;
    logic [31:0] cyc_rdata = '0;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    pcfg_xlate u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .reg_sel(reg_sel), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cyc_req(cyc_req), .cyc_write(cyc_write), .cyc_bus(cyc_bus),
        .cyc_devfn(cyc_devfn), .cyc_regofs(cyc_regofs), .cyc_wdata(cyc_wdata),
        .cyc_done(cyc_done), .cyc_err(cyc_err), .cyc_rdata(cyc_rdata)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd_reg(input logic sel, output logic [31:0] val);
        reg_sel = sel;
        #1;
        val = reg_rdata;
    endtask

    task automatic wr_reg(input logic sel, input logic [31:0] val);
        @(negedge clk);
        reg_sel = sel; reg_we = 1'b1; reg_wdata = val;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    // One full access with a bus model answering after lat wait cycles.
    task automatic do_acc(input logic [15:0] addr, input logic wr, input logic [31:0] wd,
                          input logic rerr, input logic [31:0] rd, input int lat,
                          input logic [7:0] e_bus, input logic [7:0] e_devfn,
                          input logic [5:0] e_reg, input logic [31:0] e_wd,
                          input logic [31:0] e_rsp, input string tag);
        logic [31:0] s;
        @(negedge clk);
        chk({31'd0, req_ready}, 32'd1, {tag, " R11 ready idle"});
        req_valid = 1'b1; req_addr = addr; req_write = wr; req_wdata = wd;
        @(negedge clk);
        req_addr = addr ^ 16'h0800;   // keep valid high with another target: must be ignored
        chk({31'd0, cyc_req}, 32'd1, {tag, " R9 cyc_req"});
        chk({24'd0, cyc_bus}, {24'd0, e_bus}, {tag, " R1 bus"});
        chk({24'd0, cyc_devfn}, {24'd0, e_devfn}, {tag, " R2 R3 devfn"});
        chk({26'd0, cyc_regofs}, {26'd0, e_reg}, {tag, " R2 regofs"});
        chk({31'd0, cyc_write}, {31'd0, wr}, {tag, " R2 write flag"});
        if (wr) chk(cyc_wdata, e_wd, {tag, " R7 write swap"});
        for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            chk({31'd0, req_ready}, 32'd0, {tag, " R9 ready low"});
            chk({24'd0, cyc_devfn}, {24'd0, e_devfn}, {tag, " R9 devfn held"});
        end
        req_valid = 1'b0;
        cyc_done = 1'b1; cyc_err = rerr; cyc_rdata = rd;
        @(negedge clk);
        cyc_done = 1'b0; cyc_err = 1'b0;
        chk({31'd0, rsp_valid}, 32'd1, {tag, " R12 rsp_valid"});
        chk(rsp_rdata, e_rsp, {tag, " R7 R8 rsp data"});
        chk({31'd0, cyc_req}, 32'd0, {tag, " R9 cyc released"});
        rd_reg(1'b1, s);
        chk({31'd0, s[20]}, 32'd1, {tag, " R4 done bit"});
        if (rerr) chk({31'd0, s[19]}, 32'd1, {tag, " R5 err bit"});
        @(negedge clk);
        chk({31'd0, rsp_valid}, 32'd0, {tag, " R12 pulse ends"});
    endtask

    task automatic t_reset();
        logic [31:0] s;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk({31'd0, req_ready}, 32'd1, "R11 ready");
        chk({31'd0, cyc_req}, 32'd0, "R11 cyc_req");
        chk({31'd0, rsp_valid}, 32'd0, "R11 rsp_valid");
        rd_reg(1'b1, s);
        chk(s, 32'd0, "R11 status");
        rd_reg(1'b0, s);
        chk(s, 32'd0, "R1 control reset");
    endtask

    task automatic t_ctl();
        logic [31:0] s;
        wr_reg(1'b0, 32'hFFA5_FFFF);
        rd_reg(1'b0, s);
        chk(s, 32'h00A5_0000, "R1 control readback");
        wr_reg(1'b0, 32'h0);
    endtask

    task automatic t_read_remap();
        // bus 0, slot 2 func 1 reg 5 -> devfn (8<<3)|1
        do_acc(16'h1114, 1'b0, 32'h0, 1'b0, 32'h1122_3344, 3,
               8'h00, 8'h41, 6'd5, 32'h0, 32'h4433_2211, "bus0 slot2 read");
    endtask

    task automatic t_slot0();
        do_acc(16'h0204, 1'b0, 32'h0, 1'b0, 32'h0102_0304, 0,
               8'h00, 8'h02, 6'd1, 32'h0, 32'h0403_0201, "bus0 slot0 read");
    endtask

    task automatic t_write_bus3();
        logic [31:0] s;
        wr_reg(1'b1, 32'h0018_0000);
        wr_reg(1'b0, 32'h0003_0000);
        do_acc(16'h20FC, 1'b1, 32'hAABB_CCDD, 1'b0, 32'h0, 1,
               8'h03, 8'h20, 6'h3F, 32'hDDCC_BBAA, 32'h0, "bus3 write");
        rd_reg(1'b1, s);
        chk({31'd0, s[19]}, 32'd0, "R5 clean write no err");
        wr_reg(1'b0, 32'h0);
    endtask

    task automatic t_err_and_w1c();
        logic [31:0] s;
        wr_reg(1'b1, 32'h0018_0000);
        do_acc(16'h0810, 1'b0, 32'h0, 1'b1, 32'h1234_5678, 2,
               8'h00, 8'h38, 6'd4, 32'h0, 32'hFFFF_FFFF, "err read R8");
        // next clean access must not clear error
        do_acc(16'h0000, 1'b0, 32'h0, 1'b0, 32'hCAFE_F00D, 0,
               8'h00, 8'h00, 6'd0, 32'h0, 32'h0DF0_FECA, "clean after err");
        rd_reg(1'b1, s);
        chk(s, 32'h0018_0000, "R5 err sticky across request");
        wr_reg(1'b1, 32'h0);
        rd_reg(1'b1, s);
        chk(s, 32'h0018_0000, "R6 write zero no effect");
        wr_reg(1'b1, 32'h0008_0000);
        rd_reg(1'b1, s);
        chk(s, 32'h0010_0000, "R6 clear err only");
        wr_reg(1'b1, 32'h0010_0000);
        rd_reg(1'b1, s);
        chk(s, 32'h0, "R6 clear done");
    endtask

    task automatic t_misaligned();
        logic [31:0] s;
        @(negedge clk);
        req_valid = 1'b1; req_addr = 16'h1116; req_write = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        chk({31'd0, cyc_req}, 32'd0, "R10 no cycle");
        chk({31'd0, rsp_valid}, 32'd1, "R10 immediate response");
        chk(rsp_rdata, 32'hFFFF_FFFF, "R10 misaligned read data");
        rd_reg(1'b1, s);
        chk(s, 32'h0018_0000, "R10 status done+err");
        @(negedge clk);
        chk({31'd0, cyc_req}, 32'd0, "R10 still no cycle");
        wr_reg(1'b1, 32'h0018_0000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_ctl();
        t_read_remap();
        t_slot0();
        t_write_bus3();
        t_err_and_w1c();
        t_misaligned();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule